// File: doc/BRIEF.md
# I2C Stuck-Line Detector With Recovery

This block sits beside a downstream I2C port and watches its two open-drain lines. Each line has its own low-hold timer. The timer advances on a shared timebase tick while the line stays low and starts again from zero whenever the line is seen high. When a timer reaches its limit, the stuck flag for that line is set. The flag stays set until a bus recovery sequence completes. Each flag can be routed to a common interrupt output through its own enable.

Recovery begins on a one-cycle start request. The block drives SCL low and releases it nine times, and every half-period lasts a programmable number of system clocks. SDA is released for the first eight clocks. SDA is pulled low across the ninth clock and then let go while SCL is high, which forms a STOP condition. Both stuck flags clear at the end of the sequence. Both timers are held at zero while the sequence runs.

The outputs `scl_drive_low` and `sda_drive_low` enable the pull-down of the pad. A low limit of zero selects the built-in default: 35 ticks for SCL and 1000 ticks for SDA. With a 1 ms tick, these defaults give 35 ms and 1 s.

Top module: `i2c_stuck_guard`

## Requirements
- R1: `scl_stuck` is set on the clock edge that carries the Nth tick of an unbroken low period on the synchronised SCL line, where N is `scl_limit`. It is not set after N-1 ticks.
- R2: `sda_stuck` behaves the same way for SDA, with the limit taken from `sda_limit`. The flags are independent, so a low SCL never sets `sda_stuck` and a low SDA never sets `scl_stuck`.
- R3: A limit input of 0 selects the default limit: 35 ticks for SCL and 1000 ticks for SDA.
- R4: If a line is sampled high, its timer restarts from zero. Two low periods that each have fewer than N ticks therefore never set the flag.
- R5: A stuck flag stays set after its line returns high. It clears only on the last cycle of a recovery sequence.
- R6: `irq` is high exactly when (`scl_stuck` and `scl_irq_en`) or (`sda_stuck` and `sda_irq_en`).
- R7: After a one-cycle `recover_start`, `scl_drive_low` forms nine low/high clock periods. Each half lasts `half_period` system clocks, and a value of 0 is treated as 1. `busy` stays high for 19 half-periods in total.
- R8: `sda_drive_low` stays 0 during the first eight SCL clocks. It is 1 from the start of the low half of the ninth clock until the end of that clock's high half. It then returns to 0 while SCL is released, which is a single STOP.
- R9: While `busy` is high, neither timer advances and no flag is set, even with a line low and the tick active. After recovery, a full limit of ticks is needed again to set a flag.
- R10: A `recover_start` pulse that arrives while `busy` is high is ignored, so the sequence length does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timebase pulse that advances the low-hold timers |
| scl_in | input | 1 | Sensed SCL level, synchronised internally |
| sda_in | input | 1 | Sensed SDA level, synchronised internally |
| scl_limit | input | CNT_W | SCL stuck limit in ticks, 0 selects default |
| sda_limit | input | CNT_W | SDA stuck limit in ticks, 0 selects default |
| scl_irq_en | input | 1 | Routes `scl_stuck` to `irq` |
| sda_irq_en | input | 1 | Routes `sda_stuck` to `irq` |
| half_period | input | HP_W | Recovery half-period in system clocks, 0 counts as 1 |
| recover_start | input | 1 | Starts the recovery sequence when idle |
| scl_drive_low | output | 1 | Pull SCL low |
| sda_drive_low | output | 1 | Pull SDA low |
| busy | output | 1 | Recovery sequence in progress |
| scl_stuck | output | 1 | SCL held low past its limit |
| sda_stuck | output | 1 | SDA held low past its limit |
| irq | output | 1 | Combined enabled stuck interrupt |

## Verification
The hardest case to reach is a line held low while ticks keep arriving during recovery. Only then does the pause on the timers make a visible difference. The bench holds SDA low and keeps the tick high for the whole sequence. It checks that no flag rises during the sequence. After `busy` falls, it checks that exactly the full limit of fresh ticks is needed to set the flag. A second start pulse in the middle of a sequence is also injected, and the length of `busy` is measured to show that the pulse had no effect.

// File: rtl/i2c_sg_pkg.sv
package i2c_sg_pkg;
   localparam int unsigned RECOV_CLOCKS = 9;
   localparam int unsigned RECOV_PHASES = 2 * RECOV_CLOCKS + 1;
   localparam int unsigned PH_W         = $clog2(RECOV_PHASES);
   localparam int unsigned SDA_LOW_PH   = 2 * (RECOV_CLOCKS - 1);
   typedef logic [PH_W-1:0] phase_t;
endpackage

// File: rtl/i2c_sg_sync.sv
module i2c_sg_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else if (STAGES == 1) begin : g_one
         logic r;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) r <= 1'b1;
            else        r <= d;
         assign q = r;
      end else begin : g_chain
         logic [STAGES-1:0] r;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) r <= '1;
            else        r <= {r[STAGES-2:0], d};
         assign q = r[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/i2c_sg_timer.sv
module i2c_sg_timer #(
   parameter int CNT_W     = 12,
   parameter int DEF_LIMIT = 35
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_hi,
   input  logic             tick,
   input  logic [CNT_W-1:0] limit,
   input  logic             pause,
   input  logic             clr,
   output logic             flag
);
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lim_eff;
   logic [CNT_W:0]   nxt;
   logic             hit;

   assign lim_eff = (limit == '0) ? CNT_W'(DEF_LIMIT) : limit;
   assign nxt     = {1'b0, cnt} + 1'b1;
   assign hit     = !pause && !line_hi && tick && (nxt >= {1'b0, lim_eff});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         flag <= 1'b0;
      end else begin
         if (clr)      flag <= 1'b0;
         else if (hit) flag <= 1'b1;
         if (pause || line_hi || clr)  cnt <= '0;
         else if (tick && !nxt[CNT_W]) cnt <= nxt[CNT_W-1:0];
      end
   end

   assert_flag_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      flag && !clr |=> flag);
   assert_pause_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pause |=> cnt == '0);
   assert_set_when_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(!line_hi && tick));
endmodule

// File: rtl/i2c_sg_recover.sv
module i2c_sg_recover
   import i2c_sg_pkg::*;
#(
   parameter int HP_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [HP_W-1:0] half_period,
   output logic            busy,
   output logic            done,
   output logic            scl_low,
   output logic            sda_low
);
   localparam phase_t PH_LAST = phase_t'(RECOV_PHASES - 1);
   localparam phase_t PH_SDA  = phase_t'(SDA_LOW_PH);

   phase_t          ph;
   logic [HP_W-1:0] hp;
   logic [HP_W-1:0] hp_last;
   logic            last_hp;

   assign hp_last = (half_period == '0) ? '0 : half_period - 1'b1;
   assign last_hp = (hp == hp_last);
   assign done    = busy && last_hp && (ph == PH_LAST);
   assign scl_low = busy && !ph[0] && (ph != PH_LAST);
   assign sda_low = busy && (ph >= PH_SDA) && (ph != PH_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         ph   <= '0;
         hp   <= '0;
      end else if (!busy) begin
         if (start) begin
            busy <= 1'b1;
            ph   <= '0;
            hp   <= '0;
         end
      end else if (last_hp) begin
         hp <= '0;
         if (ph == PH_LAST) busy <= 1'b0;
         else               ph   <= ph + 1'b1;
      end else begin
         hp <= hp + 1'b1;
      end
   end

   assert_stop_scl_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_low) |-> !scl_low);
   assert_sda_only_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sda_low |-> busy);
   assert_busy_from_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
endmodule

// File: rtl/i2c_stuck_guard.sv
module i2c_stuck_guard #(
   parameter int CNT_W         = 12,
   parameter int HP_W          = 8,
   parameter int DEF_SCL_LIMIT = 35,
   parameter int DEF_SDA_LIMIT = 1000,
   parameter int SYNC_STAGES   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             scl_in,
   input  logic             sda_in,
   input  logic [CNT_W-1:0] scl_limit,
   input  logic [CNT_W-1:0] sda_limit,
   input  logic             scl_irq_en,
   input  logic             sda_irq_en,
   input  logic [HP_W-1:0]  half_period,
   input  logic             recover_start,
   output logic             scl_drive_low,
   output logic             sda_drive_low,
   output logic             busy,
   output logic             scl_stuck,
   output logic             sda_stuck,
   output logic             irq
);
   localparam int NLINES = 2;

   generate
      if (CNT_W < 2 || CNT_W > 31) begin : g_bad_cnt
         $error("CNT_W out of range");
      end
      if (HP_W < 1) begin : g_bad_hp
         $error("HP_W must be positive");
      end
      if (DEF_SCL_LIMIT < 1 || DEF_SCL_LIMIT >= (1 << CNT_W)) begin : g_bad_scl
         $error("DEF_SCL_LIMIT does not fit CNT_W");
      end
      if (DEF_SDA_LIMIT < 1 || DEF_SDA_LIMIT >= (1 << CNT_W)) begin : g_bad_sda
         $error("DEF_SDA_LIMIT does not fit CNT_W");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   logic             done;
   logic [NLINES-1:0] raw;
   logic [NLINES-1:0] synced;
   logic [NLINES-1:0] flags;
   logic [NLINES-1:0] enables;
   logic [CNT_W-1:0]  limits [NLINES];

   assign raw       = {sda_in, scl_in};
   assign enables   = {sda_irq_en, scl_irq_en};
   assign limits[0] = scl_limit;
   assign limits[1] = sda_limit;

   for (genvar i = 0; i < NLINES; i++) begin : g_line
      i2c_sg_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk(clk), .rst_n(rst_n), .d(raw[i]), .q(synced[i]));
      i2c_sg_timer #(
         .CNT_W(CNT_W),
         .DEF_LIMIT((i == 0) ? DEF_SCL_LIMIT : DEF_SDA_LIMIT)
      ) u_timer (
         .clk(clk), .rst_n(rst_n), .line_hi(synced[i]), .tick(tick),
         .limit(limits[i]), .pause(busy), .clr(done), .flag(flags[i]));
   end

   i2c_sg_recover #(.HP_W(HP_W)) u_recover (
      .clk(clk), .rst_n(rst_n), .start(recover_start),
      .half_period(half_period), .busy(busy), .done(done),
      .scl_low(scl_drive_low), .sda_low(sda_drive_low));

   assign scl_stuck = flags[0];
   assign sda_stuck = flags[1];
   assign irq       = |(flags & enables);

   assert_scl_clear_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(scl_stuck) |-> $past(busy) && !busy);
   assert_sda_clear_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_stuck) |-> $past(busy) && !busy);
   assert_no_set_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !scl_stuck && !sda_stuck |=> !scl_stuck && !sda_stuck);
endmodule

// File: tb/i2c_stuck_guard_tb.sv
module i2c_stuck_guard_tb;
   localparam int CNT_W = 12;
   localparam int HP_W  = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0, scl_in = 1'b1, sda_in = 1'b1;
   logic [CNT_W-1:0] scl_limit = '0, sda_limit = '0;
   logic scl_irq_en = 1'b1, sda_irq_en = 1'b1;
   logic [HP_W-1:0] half_period = 8'd1;
   logic recover_start = 1'b0;
   logic scl_drive_low, sda_drive_low, busy, scl_stuck, sda_stuck, irq;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   i2c_stuck_guard u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .scl_in(scl_in), .sda_in(sda_in),
      .scl_limit(scl_limit), .sda_limit(sda_limit),
      .scl_irq_en(scl_irq_en), .sda_irq_en(sda_irq_en),
      .half_period(half_period), .recover_start(recover_start),
      .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
      .busy(busy), .scl_stuck(scl_stuck), .sda_stuck(sda_stuck), .irq(irq));

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
      end
      @(negedge clk);
   endtask

   // Runs one recovery and measures its shape; restarts mid-sequence if asked.
   task automatic run_recovery(input int hp, input bit restart_mid, input bit tick_during,
                               output int busy_cyc, output int rises, output int stops,
                               output int early_sda);
      bit prev_scl = 1'b0, prev_sda = 1'b0;
      busy_cyc = 0; rises = 0; stops = 0; early_sda = 0;
      half_period = HP_W'(hp);
      @(negedge clk); recover_start = 1'b1;
      @(negedge clk); recover_start = 1'b0;
      if (tick_during) tick = 1'b1;
      while (busy && busy_cyc < 2000) begin
         busy_cyc++;
         if (prev_scl && !scl_drive_low) rises++;
         if (prev_sda && !sda_drive_low && !scl_drive_low) stops++;
         if (sda_drive_low && rises < 8) early_sda++;
         prev_scl = scl_drive_low;
         prev_sda = sda_drive_low;
         if (restart_mid && busy_cyc == 10) recover_start = 1'b1;
         if (restart_mid && busy_cyc == 11) recover_start = 1'b0;
         @(negedge clk);
      end
      tick = 1'b0;
   endtask

   task automatic clear_flags();
      int b, r, s, e;
      run_recovery(1, 1'b0, 1'b0, b, r, s, e);
   endtask

   task automatic t_reset();
      chk("R5 reset scl_stuck", scl_stuck, 0);
      chk("R5 reset sda_stuck", sda_stuck, 0);
      chk("R7 reset busy", busy, 0);
      chk("R8 reset sda_drive_low", sda_drive_low, 0);
      chk("R6 reset irq", irq, 0);
   endtask

   task automatic t_scl_limit();
      scl_limit = 12'd5; scl_in = 1'b0; wait_cyc(4);
      ticks(4);
      chk("R1 scl after N-1 ticks", scl_stuck, 0);
      ticks(1);
      chk("R1 scl after N ticks", scl_stuck, 1);
      chk("R2 sda unaffected by scl", sda_stuck, 0);
      chk("R6 irq with scl enabled", irq, 1);
      scl_irq_en = 1'b0; @(negedge clk);
      chk("R6 irq with scl disabled", irq, 0);
      scl_irq_en = 1'b1;
      scl_in = 1'b1; wait_cyc(6); ticks(3);
      chk("R5 scl flag sticky after release", scl_stuck, 1);
      clear_flags();
      chk("R5 scl flag cleared by recovery", scl_stuck, 0);
   endtask

   task automatic t_sda_limit();
      sda_limit = 12'd3; sda_in = 1'b0; wait_cyc(4);
      ticks(2);
      chk("R2 sda after N-1 ticks", sda_stuck, 0);
      ticks(1);
      chk("R2 sda after N ticks", sda_stuck, 1);
      chk("R2 scl unaffected by sda", scl_stuck, 0);
      sda_irq_en = 1'b0; @(negedge clk);
      chk("R6 irq with sda disabled", irq, 0);
      sda_irq_en = 1'b1; @(negedge clk);
      chk("R6 irq with sda enabled", irq, 1);
      sda_in = 1'b1; wait_cyc(4);
      clear_flags();
      chk("R5 sda cleared by recovery", sda_stuck, 0);
   endtask

   task automatic t_restart();
      scl_limit = 12'd5; scl_in = 1'b0; wait_cyc(4);
      ticks(4);
      scl_in = 1'b1; wait_cyc(4);
      scl_in = 1'b0; wait_cyc(4);
      ticks(4);
      chk("R4 timer restarted after high", scl_stuck, 0);
      ticks(1);
      chk("R4 flag after full fresh count", scl_stuck, 1);
      scl_in = 1'b1; wait_cyc(4);
      clear_flags();
   endtask

   task automatic t_defaults();
      scl_limit = '0; sda_limit = '0;
      scl_in = 1'b0; wait_cyc(4);
      ticks(34);
      chk("R3 scl default minus one", scl_stuck, 0);
      ticks(1);
      chk("R3 scl default 35", scl_stuck, 1);
      scl_in = 1'b1; sda_in = 1'b0; wait_cyc(4);
      ticks(999);
      chk("R3 sda default minus one", sda_stuck, 0);
      ticks(1);
      chk("R3 sda default 1000", sda_stuck, 1);
      sda_in = 1'b1; wait_cyc(4);
      clear_flags();
   endtask

   task automatic t_sequence(input int hp, input int eff);
      int b, r, s, e;
      run_recovery(hp, 1'b0, 1'b0, b, r, s, e);
      chk("R7 busy length", b, 19 * eff);
      chk("R7 nine SCL rises", r, 9);
      chk("R8 single STOP", s, 1);
      chk("R8 SDA released first eight clocks", e, 0);
      chk("R8 sda released after", sda_drive_low, 0);
   endtask

   task automatic t_restart_ignored();
      int b, r, s, e;
      run_recovery(2, 1'b1, 1'b0, b, r, s, e);
      chk("R10 restart ignored length", b, 38);
      chk("R10 restart ignored rises", r, 9);
   endtask

   task automatic t_pause();
      int b, r, s, e;
      sda_limit = 12'd4; sda_in = 1'b0; wait_cyc(4);
      run_recovery(3, 1'b0, 1'b1, b, r, s, e);
      chk("R9 no flag set during busy", sda_stuck, 0);
      chk("R9 busy length with ticks", b, 57);
      ticks(3);
      chk("R9 fresh count after recovery minus one", sda_stuck, 0);
      ticks(1);
      chk("R9 fresh count after recovery", sda_stuck, 1);
      sda_in = 1'b1; wait_cyc(4);
      clear_flags();
   endtask

   initial begin
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(2);
      t_reset();
      t_scl_limit();
      t_sda_limit();
      t_restart();
      t_defaults();
      t_sequence(3, 3);
      t_sequence(0, 1);
      t_restart_ignored();
      t_pause();
      if (!finished) begin
         finished = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 150000; i++) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++; n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end
endmodule